// File: doc/BRIEF.md
# Control Endpoint Setup and Prime Coherency Registers

This block holds the software-visible state that keeps a USB device controller's control endpoints coherent when a new setup packet arrives while software is still working on the previous one. For every endpoint it keeps three bits. A setup-seen flag is raised by the packet engine and cleared by software writing 1. A prime request is set by software and retired by the packet engine. An endpoint-ready flag reports that a prime was accepted. A single global tripwire bit lets software find out whether a setup buffer was overwritten while it was copying that buffer. Software sets the tripwire, copies the buffer, and then reads the tripwire back. If the bit is still 1, the copy is valid.

A setup arrival on an endpoint overrides everything that was in flight on that endpoint. A pending prime is dropped, which software sees as a failed prime: the request bit falls and the ready bit stays 0. A ready bit that was already set is cleared, so a data stage primed for an older setup is never used with the new one. Clearing a setup-seen bit by software takes effect only after a configurable number of cycles. This models the short settle time that software must poll through.

The register port is a single-cycle write strobe with an address and write data. Read data is a combinational function of the address. Bit i of each register maps to endpoint i.

Top module: `ctl_ep_coherency`

## Requirements
- R1: After reset, every readable address (0 to 7) returns 0.
- R2: A pulse on `setup_rx[i]` sets bit i of the setup-seen register (address 1) on the next clock edge.
- R3: Writing 1 to bit i at address 1 clears that bit exactly `CLR_DELAY` clock edges after the write edge, and the bit still reads 1 one edge earlier. Writing 0 has no effect. A `setup_rx[i]` pulse while that clear is pending cancels the clear, so the bit stays 1.
- R4: Bit 0 of address 0 is the tripwire. A write of 1 sets it and a write of 0 clears it. A pulse on any `setup_rx` bit clears it on the next edge, and this clear wins over a software write of 1 in the same cycle.
- R5: At address 2, writing 1 to bit i sets prime request i, and writing 0 has no effect. A request bit falls only on `prime_ack[i]`, `prime_nak[i]` or `setup_rx[i]`.
- R6: `prime_ack[i]` clears prime request i and sets ready bit i (address 3). `prime_nak[i]` clears the request and leaves ready bit i at 0.
- R7: `setup_rx[i]` clears both prime request i and ready bit i on the next edge. It overrides a `prime_ack[i]` in the same cycle, so the result reads as a failed prime.
- R8: Ready bit i is cleared by writing 1 to bit i of the flush address 4 or by a pulse on `xfer_done[i]`. A clear in the same cycle as `prime_ack[i]` wins.
- R9: Address 3 is read-only. Addresses 4 to 7 read as 0. Writes to addresses 3, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | NUM_EP | Register write data |
| reg_rdata | output | NUM_EP | Register read data, combinational from `reg_addr` |
| setup_rx | input | NUM_EP | Setup packet landed on the endpoint, one-cycle pulse |
| prime_ack | input | NUM_EP | Packet engine accepted the prime on the endpoint |
| prime_nak | input | NUM_EP | Packet engine rejected the prime on the endpoint |
| xfer_done | input | NUM_EP | Transfer completed on the endpoint, which drops ready |

## Verification
The bench targets the races. In one test a setup lands while a prime is pending. In another a setup coincides with the acceptance of that prime. A design that honours the acceptance in either case would report a ready endpoint holding stale data. The bench also lands a setup in the same cycle as a software write that sets the tripwire. A design where software wins would hide an overwritten setup buffer. The delayed setup-flag clear is checked on both sides of its exact edge, and a fresh setup is sent while that clear is pending. A design without cancellation would lose the new setup flag, and an off-by-one pipeline would clear one edge early or late.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SETUP = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRIME = 3'd2;
  localparam logic [ADDR_W-1:0] A_READY = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLUSH = 3'd4;
endpackage

// File: rtl/ctl_ep_rstsync.sv
module ctl_ep_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ctl_ep_regif.sv
module ctl_ep_regif
  import ctl_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 4
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_EP-1:0] reg_wdata,
  output logic [NUM_EP-1:0] reg_rdata,
  input  logic              trip_q,
  input  logic [NUM_EP-1:0] stat_q,
  input  logic [NUM_EP-1:0] prime_q,
  input  logic [NUM_EP-1:0] ready_q,
  output logic              cmd_wr,
  output logic              cmd_bit,
  output logic [NUM_EP-1:0] clr_mask,
  output logic [NUM_EP-1:0] prime_set,
  output logic [NUM_EP-1:0] flush_mask
);
  // Write decode: each strobe carries its write data as a mask.
  always_comb begin
    cmd_wr     = reg_wr && (reg_addr == A_CMD);
    cmd_bit    = reg_wdata[0];
    clr_mask   = (reg_wr && (reg_addr == A_SETUP)) ? reg_wdata : '0;
    prime_set  = (reg_wr && (reg_addr == A_PRIME)) ? reg_wdata : '0;
    flush_mask = (reg_wr && (reg_addr == A_FLUSH)) ? reg_wdata : '0;
  end

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:   reg_rdata[0] = trip_q;
      A_SETUP: reg_rdata    = stat_q;
      A_PRIME: reg_rdata    = prime_q;
      A_READY: reg_rdata    = ready_q;
      default: reg_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/ctl_ep_setup.sv
module ctl_ep_setup #(
  parameter int unsigned NUM_EP    = 4,
  parameter int unsigned CLR_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic [NUM_EP-1:0] setup_rx,
  input  logic [NUM_EP-1:0] clr_mask,
  input  logic              cmd_wr,
  input  logic              cmd_bit,
  output logic [NUM_EP-1:0] stat_q,
  output logic              trip_q
);
  localparam int unsigned STAGES = (CLR_DELAY < 1) ? 1 : CLR_DELAY;

  logic [STAGES-1:0][NUM_EP-1:0] pend_q;
  logic [STAGES-1:0][NUM_EP-1:0] pend_d;
  logic [NUM_EP-1:0] apply;
  logic [NUM_EP-1:0] stat_d;
  logic              stat_en;
  logic              any_setup;
  logic              trip_d;
  logic              trip_en;

  // Pending-clear pipeline. A setup on an endpoint drops its pending clear.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign pend_d[s] = clr_mask & ~setup_rx;
      end else begin : g_body
        assign pend_d[s] = pend_q[s-1] & ~setup_rx;
      end
    end
  endgenerate

  assign apply     = pend_q[STAGES-1];
  assign any_setup = |setup_rx;

  always_comb begin
    stat_d  = (stat_q & ~apply) | setup_rx;
    stat_en = any_setup || (|apply);
    trip_d  = any_setup ? 1'b0 : cmd_bit;
    trip_en = any_setup || cmd_wr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     trip_q <= 1'b0;
    else if (trip_en) trip_q <= trip_d;
  end
endmodule

// File: rtl/ctl_ep_prime.sv
module ctl_ep_prime #(
  parameter int unsigned NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic [NUM_EP-1:0] prime_set,
  input  logic [NUM_EP-1:0] flush_mask,
  input  logic [NUM_EP-1:0] setup_rx,
  input  logic [NUM_EP-1:0] prime_ack,
  input  logic [NUM_EP-1:0] prime_nak,
  input  logic [NUM_EP-1:0] xfer_done,
  output logic [NUM_EP-1:0] prime_q,
  output logic [NUM_EP-1:0] ready_q
);
  generate
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      logic retire;
      logic kill;
      logic prime_d;
      logic prime_en;
      logic ready_d;
      logic ready_en;

      always_comb begin
        retire   = prime_ack[i] | prime_nak[i] | setup_rx[i];
        kill     = setup_rx[i] | flush_mask[i] | xfer_done[i];
        prime_d  = prime_set[i] & ~retire;
        prime_en = prime_set[i] | retire;
        ready_d  = prime_ack[i] & ~kill;
        ready_en = prime_ack[i] | kill;
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n)      prime_q[i] <= 1'b0;
        else if (prime_en) prime_q[i] <= prime_d;
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n)      ready_q[i] <= 1'b0;
        else if (ready_en) ready_q[i] <= ready_d;
      end
    end
  endgenerate
endmodule

// File: rtl/ctl_ep_coherency.sv
module ctl_ep_coherency
  import ctl_ep_pkg::*;
#(
  parameter int unsigned NUM_EP    = 4,
  parameter int unsigned CLR_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_EP-1:0] reg_wdata,
  output logic [NUM_EP-1:0] reg_rdata,
  input  logic [NUM_EP-1:0] setup_rx,
  input  logic [NUM_EP-1:0] prime_ack,
  input  logic [NUM_EP-1:0] prime_nak,
  input  logic [NUM_EP-1:0] xfer_done
);
  logic              rst_q_n;
  logic              trip_q;
  logic [NUM_EP-1:0] stat_q;
  logic [NUM_EP-1:0] prime_q;
  logic [NUM_EP-1:0] ready_q;
  logic              cmd_wr;
  logic              cmd_bit;
  logic [NUM_EP-1:0] clr_mask;
  logic [NUM_EP-1:0] prime_set;
  logic [NUM_EP-1:0] flush_mask;

  ctl_ep_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ctl_ep_regif #(.NUM_EP(NUM_EP)) u_regif (
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trip_q     (trip_q),
    .stat_q     (stat_q),
    .prime_q    (prime_q),
    .ready_q    (ready_q),
    .cmd_wr     (cmd_wr),
    .cmd_bit    (cmd_bit),
    .clr_mask   (clr_mask),
    .prime_set  (prime_set),
    .flush_mask (flush_mask)
  );

  ctl_ep_setup #(.NUM_EP(NUM_EP), .CLR_DELAY(CLR_DELAY)) u_setup (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .setup_rx (setup_rx),
    .clr_mask (clr_mask),
    .cmd_wr   (cmd_wr),
    .cmd_bit  (cmd_bit),
    .stat_q   (stat_q),
    .trip_q   (trip_q)
  );

  ctl_ep_prime #(.NUM_EP(NUM_EP)) u_prime (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .prime_set  (prime_set),
    .flush_mask (flush_mask),
    .setup_rx   (setup_rx),
    .prime_ack  (prime_ack),
    .prime_nak  (prime_nak),
    .xfer_done  (xfer_done),
    .prime_q    (prime_q),
    .ready_q    (ready_q)
  );
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk #(
  parameter int unsigned NUM_EP    = 4,
  parameter int unsigned CLR_DELAY = 3
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [NUM_EP-1:0] setup_rx,
  input logic [NUM_EP-1:0] prime_ack,
  input logic [NUM_EP-1:0] prime_nak,
  input logic [NUM_EP-1:0] clr_mask,
  input logic [NUM_EP-1:0] stat_q,
  input logic              trip_q,
  input logic [NUM_EP-1:0] prime_q,
  input logic [NUM_EP-1:0] ready_q
);
  // R2: a setup pulse raises its setup-seen bit on the next edge
  a_r2_setup_sets: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|setup_rx) |=> ((stat_q & $past(setup_rx)) == $past(setup_rx)));

  // R4: any setup leaves the tripwire at 0
  a_r4_trip_cleared: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|setup_rx) |=> !trip_q);

  // R5: a prime request falls only on ack, nak or setup
  a_r5_prime_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((($past(prime_q) & ~prime_q) & ~$past(prime_ack | prime_nak | setup_rx)) == '0));

  // R7: a setup wipes prime and ready on its endpoint
  a_r7_setup_kills: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|setup_rx) |=> (((prime_q | ready_q) & $past(setup_rx)) == '0));

  // R3: the setup-seen clear never lands on the edge right after the write
  generate
    if (CLR_DELAY > 1) begin : g_early
      a_r3_no_early_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
        (|clr_mask) |=> (((~stat_q) & $past(stat_q) & $past(clr_mask)) == '0));
    end
  endgenerate
endmodule

bind ctl_ep_coherency ctl_ep_chk #(.NUM_EP(NUM_EP), .CLR_DELAY(CLR_DELAY)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .setup_rx  (setup_rx),
  .prime_ack (prime_ack),
  .prime_nak (prime_nak),
  .clr_mask  (clr_mask),
  .stat_q    (stat_q),
  .trip_q    (trip_q),
  .prime_q   (prime_q),
  .ready_q   (ready_q)
);

// File: tb/test_ctl_ep_coherency.sv
`timescale 1ns/1ps
module test_ctl_ep_coherency;
  localparam int unsigned N  = 4;
  localparam int unsigned CD = 3;

  logic         clk;
  logic         rst_n;
  logic         reg_wr;
  logic [2:0]   reg_addr;
  logic [N-1:0] reg_wdata;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] setup_rx;
  logic [N-1:0] prime_ack;
  logic [N-1:0] prime_nak;
  logic [N-1:0] xfer_done;

  int checks;
  int fails;

  ctl_ep_coherency #(.NUM_EP(N), .CLR_DELAY(CD)) i_ctl_ep_coherency (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .setup_rx  (setup_rx),
    .prime_ack (prime_ack),
    .prime_nak (prime_nak),
    .xfer_done (xfer_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a negedge; returns at the next negedge.
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [N-1:0] d,
                     input logic [N-1:0] su, input logic [N-1:0] ak,
                     input logic [N-1:0] nk, input logic [N-1:0] dn);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    setup_rx = su; prime_ack = ak; prime_nak = nk; xfer_done = dn;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    setup_rx = '0; prime_ack = '0; prime_nak = '0; xfer_done = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    cyc(1'b1, a, d, '0, '0, '0, '0);
  endtask

  task automatic ev(input logic [N-1:0] su, input logic [N-1:0] ak,
                    input logic [N-1:0] nk, input logic [N-1:0] dn);
    cyc(1'b0, 3'd0, '0, su, ak, nk, dn);
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, '0);
    end
  endtask

  task automatic t_setup_clear();
    logic [N-1:0] v;
    ev(4'b0011, '0, '0, '0);
    rd(3'd1, v); chk("R2 setup sets status", v, 4'b0011);
    wr(3'd1, 4'b0000);
    rd(3'd1, v); chk("R3 write 0 no effect", v, 4'b0011);
    wr(3'd1, 4'b0001);                 // write edge k
    for (int c = 1; c < CD; c++) begin
      rd(3'd1, v); chk("R3 still set before delay", v, 4'b0011);
      @(negedge clk);
    end
    rd(3'd1, v); chk("R3 still set one edge early", v, 4'b0011);
    @(negedge clk);
    rd(3'd1, v); chk("R3 cleared at delay", v, 4'b0010);
  endtask

  task automatic t_clear_race();
    logic [N-1:0] v;
    wr(3'd1, 4'b0010);                 // pending clear on ep1
    ev(4'b0010, '0, '0, '0);           // new setup on ep1 while pending
    for (int c = 0; c < CD + 2; c++) @(negedge clk);
    rd(3'd1, v); chk("R3 setup cancels pending clear", v, 4'b0010);
    wr(3'd1, 4'b0010);
    for (int c = 0; c < CD + 1; c++) @(negedge clk);
    rd(3'd1, v); chk("R3 later clear completes", v, 4'b0000);
  endtask

  task automatic t_tripwire();
    logic [N-1:0] v;
    wr(3'd0, 4'b0001);
    rd(3'd0, v); chk("R4 tripwire set", v, 4'b0001);
    wr(3'd0, 4'b0000);
    rd(3'd0, v); chk("R4 tripwire cleared by sw", v, 4'b0000);
    wr(3'd0, 4'b0001);
    ev(4'b0100, '0, '0, '0);
    rd(3'd0, v); chk("R4 setup trips wire", v, 4'b0000);
    cyc(1'b1, 3'd0, 4'b0001, 4'b1000, '0, '0, '0);
    rd(3'd0, v); chk("R4 setup wins over sw set", v, 4'b0000);
    wr(3'd1, 4'b1100);
    for (int c = 0; c < CD; c++) @(negedge clk);
  endtask

  task automatic t_prime();
    logic [N-1:0] v;
    wr(3'd2, 4'b0011);
    rd(3'd2, v); chk("R5 prime set", v, 4'b0011);
    wr(3'd2, 4'b0000);
    rd(3'd2, v); chk("R5 write 0 no effect", v, 4'b0011);
    ev('0, 4'b0001, 4'b0010, '0);
    rd(3'd2, v); chk("R6 prime retired", v, 4'b0000);
    rd(3'd3, v); chk("R6 ack ready, nak not", v, 4'b0001);
  endtask

  task automatic t_setup_prime_race();
    logic [N-1:0] v;
    wr(3'd2, 4'b0100);
    ev(4'b0100, '0, '0, '0);
    rd(3'd2, v); chk("R7 setup fails pending prime", v, 4'b0000);
    rd(3'd3, v); chk("R7 ready stays 0", v, 4'b0001);
    wr(3'd2, 4'b1000);
    ev(4'b1000, 4'b1000, '0, '0);
    rd(3'd2, v); chk("R7 prime cleared on race", v, 4'b0000);
    rd(3'd3, v); chk("R7 setup beats ack", v, 4'b0001);
    ev(4'b0001, '0, '0, '0);
    rd(3'd3, v); chk("R7 setup drops ready", v, 4'b0000);
    wr(3'd1, 4'b1101);
    for (int c = 0; c < CD; c++) @(negedge clk);
  endtask

  task automatic t_flush();
    logic [N-1:0] v;
    wr(3'd2, 4'b1111);
    ev('0, 4'b1111, '0, '0);
    rd(3'd3, v); chk("R8 all ready", v, 4'b1111);
    wr(3'd4, 4'b0101);
    rd(3'd3, v); chk("R8 flush clears", v, 4'b1010);
    ev('0, '0, '0, 4'b0010);
    rd(3'd3, v); chk("R8 done clears", v, 4'b1000);
    wr(3'd2, 4'b0001);
    ev('0, 4'b0001, '0, 4'b0001);
    rd(3'd3, v); chk("R8 done beats ack", v, 4'b1000);
  endtask

  task automatic t_map();
    logic [N-1:0] v;
    wr(3'd3, 4'b0111);
    rd(3'd3, v); chk("R9 ready read-only", v, 4'b1000);
    wr(3'd5, 4'b1111); wr(3'd6, 4'b1111); wr(3'd7, 4'b1111);
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v); chk("R9 high addr reads 0", v, '0);
    end
    rd(3'd0, v); chk("R9 no side effect cmd", v, '0);
    rd(3'd1, v); chk("R9 no side effect setup", v, '0);
    rd(3'd2, v); chk("R9 no side effect prime", v, '0);
    rd(3'd3, v); chk("R9 no side effect ready", v, 4'b1000);
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    setup_rx = '0; prime_ack = '0; prime_nak = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_setup_clear();
    t_clear_race();
    t_tripwire();
    t_prime();
    t_setup_prime_race();
    t_flush();
    t_map();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule